// File: doc/BRIEF.md
# I2C Master STOP Sequencer with Bus-Collision Detection

This block produces the STOP condition for an I2C master on open-drain SDA and SCL lines. It never drives a line high. It only asserts a drive-low enable for each line, and it reads both lines back through a two-flop synchronizer. A software request starts the sequence. The block holds SDA low and then lets SCL go. A slave may stretch the clock, so the block waits until SCL is seen high. It then holds that state for one baud period and releases SDA. After a further baud period it checks that SDA really went high.

Another master may hold a line low while the STOP runs. If SCL drops back low before SDA has been released, the block declares a bus collision. It also declares one if SDA still reads low at the final check. On a collision it abandons the STOP, lets go of both lines and raises a sticky collision flag. A clean STOP raises a completion flag and a stop-detected flag instead. All three flags are cleared by a write-one-to-clear strobe.

Top module: `i2c_stop_seq`

## Requirements
- R1: After reset, `stop_en`, all three flags and both drive-low enables are 0. Whenever `stop_en` is 0, both drive-low enables are 0.
- R2: A `stop_set` pulse while `stop_en` is 0 makes `stop_en`, `sda_drive_low` and `scl_drive_low` all 1 on the next clock.
- R3: SCL stays driven low until SDA has been seen low through the synchronizer. With a free bus, both lines are driven together for exactly 3 cycles. SCL is released while SDA is still driven.
- R4: While another device holds SCL low after it is released (clock stretching), SDA stays driven low and the sequence waits without limit.
- R5: With N = max(`baud_reload`, 1), SDA stays driven low for exactly N+4 cycles in which the SCL line is high. SDA is then released.
- R6: If SDA reads high, then N+3 cycles after SDA is released `stop_en` falls. In the same cycle `done_flag` and `stop_det_flag` rise, `bcl_flag` stays 0, and both lines are released.
- R7: If SDA still reads low at the end of the baud period after its release, `bcl_flag` is set, `stop_en` falls, `done_flag` and `stop_det_flag` stay 0, and both lines are released.
- R8: If SCL is seen low after it was seen high and before SDA is released, `bcl_flag` is set and `stop_en` falls. SDA is never released while `stop_en` is 1, and `done_flag` and `stop_det_flag` stay 0.
- R9: A `stop_set` pulse while `stop_en` is 1 is ignored. The running sequence keeps its timing, and no second sequence follows it.
- R10: The flags are sticky. `clr_flags` bit 0 clears `done_flag`, bit 1 clears `stop_det_flag`, bit 2 clears `bcl_flag`. A clear bit leaves the other flags unchanged, and a set in the same cycle wins over the clear.
- R11: A `baud_reload` of 0 gives the same phase lengths as a reload of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_set | input | 1 | Request pulse that starts a STOP |
| clr_flags | input | 3 | Write-one-to-clear strobes: bit0 done, bit1 stop-detected, bit2 collision |
| baud_reload | input | 7 | Baud period reload value |
| sda_in | input | 1 | SDA line level from the pad |
| scl_in | input | 1 | SCL line level from the pad |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| stop_en | output | 1 | STOP sequence in progress |
| done_flag | output | 1 | Sticky completion interrupt flag |
| stop_det_flag | output | 1 | Sticky STOP-detected flag |
| bcl_flag | output | 1 | Sticky bus-collision flag |

## Verification
The bench builds the block with its default 7-bit reload and a two-stage synchronizer. That makes every reload value from 0 to 127 short enough to sweep in full. Each run varies the clock-stretch length, and the bench checks the phase cycle counts against N+4 and N+3 for each one. Directed runs add a foreign master pulling SDA low, a foreign master pulling SCL low during the high phase, and a repeated request mid-sequence. The flag-clear strobes are checked bit by bit.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SDA_LO,
    ST_SCL_REL,
    ST_SCL_HI,
    ST_SDA_REL
  } stop_state_t;

  localparam int FLG_DONE = 0;
  localparam int FLG_PDET = 1;
  localparam int FLG_BCL  = 2;
  localparam int FLG_NUM  = 3;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '1;
        else        stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '1;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_stop_timer.sv
module i2c_stop_timer #(
  parameter int RELOAD_W = 7,
  parameter int EXTRA    = 2,
  localparam int CW      = RELOAD_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                long_phase,
  input  logic [RELOAD_W-1:0] reload,
  output logic                zero
);
  logic [CW-1:0] cnt_q, cnt_d, base, load_val;

  always_comb begin
    base     = (reload == '0) ? CW'(1) : CW'(reload);
    load_val = base + (long_phase ? CW'(EXTRA) : '0);
    cnt_d    = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/i2c_stop_flags.sv
module i2c_stop_flags #(
  parameter int NUM = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] set,
  input  logic [NUM-1:0] clr,
  output logic [NUM-1:0] q
);
  for (genvar i = 0; i < NUM; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q[i] <= 1'b0;
      else if (set[i] || clr[i]) q[i] <= set[i];
    end
  end
endmodule

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq
  import i2c_stop_pkg::*;
#(
  parameter int RELOAD_W    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop_set,
  input  logic [2:0]          clr_flags,
  input  logic [RELOAD_W-1:0] baud_reload,
  input  logic                sda_in,
  input  logic                scl_in,
  output logic                sda_drive_low,
  output logic                scl_drive_low,
  output logic                stop_en,
  output logic                done_flag,
  output logic                stop_det_flag,
  output logic                bcl_flag
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [1:0] line_s;
  logic       sda_s, scl_s;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({scl_in, sda_in}),
    .q     (line_s)
  );
  assign sda_s = line_s[0];
  assign scl_s = line_s[1];

  stop_state_t         state_q, state_d;
  logic                tmr_load, tmr_long, tmr_zero;
  logic [FLG_NUM-1:0]  flag_set, flag_q;

  i2c_stop_timer #(.RELOAD_W(RELOAD_W), .EXTRA(SYNC_STAGES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (tmr_load),
    .long_phase (tmr_long),
    .reload     (baud_reload),
    .zero       (tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_long = 1'b0;
    flag_set = '0;
    unique case (state_q)
      ST_IDLE:    if (stop_set) state_d = ST_SDA_LO;
      ST_SDA_LO:  if (!sda_s)   state_d = ST_SCL_REL;
      ST_SCL_REL: if (scl_s) begin
        state_d  = ST_SCL_HI;
        tmr_load = 1'b1;
      end
      ST_SCL_HI: begin
        if (!scl_s) begin
          state_d           = ST_IDLE;
          flag_set[FLG_BCL] = 1'b1;
        end else if (tmr_zero) begin
          state_d  = ST_SDA_REL;
          tmr_load = 1'b1;
          tmr_long = 1'b1;
        end
      end
      ST_SDA_REL: if (tmr_zero) begin
        state_d = ST_IDLE;
        if (!sda_s) begin
          flag_set[FLG_BCL] = 1'b1;
        end else begin
          flag_set[FLG_DONE] = 1'b1;
          flag_set[FLG_PDET] = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  i2c_stop_flags #(.NUM(FLG_NUM)) u_flags (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set   (flag_set),
    .clr   (clr_flags),
    .q     (flag_q)
  );

  assign sda_drive_low = (state_q == ST_SDA_LO) || (state_q == ST_SCL_REL) ||
                         (state_q == ST_SCL_HI);
  assign scl_drive_low = (state_q == ST_SDA_LO);
  assign stop_en       = (state_q != ST_IDLE);
  assign done_flag     = flag_q[FLG_DONE];
  assign stop_det_flag = flag_q[FLG_PDET];
  assign bcl_flag      = flag_q[FLG_BCL];
endmodule

// File: rtl/i2c_stop_seq_chk.sv
module i2c_stop_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic stop_set,
  input logic sda_drive_low,
  input logic scl_drive_low,
  input logic stop_en,
  input logic done_flag,
  input logic bcl_flag
);
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_en |-> (!sda_drive_low && !scl_drive_low));

  p_start_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_en && stop_set) |=> (stop_en && sda_drive_low && scl_drive_low));

  p_scl_after_sda_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drive_low) |-> sda_drive_low);

  p_sda_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drive_low) |-> !scl_drive_low);

  p_done_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> ($fell(stop_en) && !$rose(bcl_flag)));

  p_bcl_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bcl_flag) |-> $fell(stop_en));
endmodule

bind i2c_stop_seq i2c_stop_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .stop_set      (stop_set),
  .sda_drive_low (sda_drive_low),
  .scl_drive_low (scl_drive_low),
  .stop_en       (stop_en),
  .done_flag     (done_flag),
  .bcl_flag      (bcl_flag)
);

// File: tb/i2c_stop_seq_bench.sv
module i2c_stop_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_set = 1'b0;
  logic [2:0] clr_flags = 3'b000;
  logic [6:0] baud_reload = 7'd1;
  logic       tb_sda_pull = 1'b0, tb_scl_pull = 1'b0;
  logic       sda_line, scl_line;
  logic       sda_drive_low, scl_drive_low, stop_en, done_flag, stop_det_flag, bcl_flag;
  int         checks = 0, errors = 0;

  always #2 clk = ~clk;

  assign sda_line = ~(sda_drive_low | tb_sda_pull);
  assign scl_line = ~(scl_drive_low | tb_scl_pull);

  i2c_stop_seq u_i2c_stop_seq (
    .clk(clk), .rst_n(rst_n), .stop_set(stop_set), .clr_flags(clr_flags),
    .baud_reload(baud_reload), .sda_in(sda_line), .scl_in(scl_line),
    .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low), .stop_en(stop_en),
    .done_flag(done_flag), .stop_det_flag(stop_det_flag), .bcl_flag(bcl_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_clr(input logic [2:0] v);
    @(posedge clk); #1 clr_flags = v;
    @(posedge clk); #1 clr_flags = 3'b000;
    @(negedge clk);
  endtask

  task automatic run_stop(input int reload, input int stretch, input bit sda_coll,
                          input bit scl_coll, input bit poke);
    int n, c_both, c_hi, c_rel, left, iter;
    bit sda_rel_seen, pulled;
    n = (reload == 0) ? 1 : reload;
    pulse_clr(3'b111);
    baud_reload = 7'(reload);
    tb_sda_pull = sda_coll;
    tb_scl_pull = (stretch > 0);
    left = stretch; c_both = 0; c_hi = 0; c_rel = 0; iter = 0;
    sda_rel_seen = 0; pulled = 0;
    @(posedge clk); #1 stop_set = 1'b1;
    @(posedge clk); #1 stop_set = 1'b0;
    while (iter < 2000) begin
      iter++;
      @(negedge clk);
      if (!stop_en) break;
      if (sda_drive_low && scl_drive_low) c_both++;
      if (scl_line && sda_drive_low) c_hi++;
      if (!sda_drive_low && sda_line) c_rel++;
      if (!sda_drive_low) sda_rel_seen = 1;
      @(posedge clk); #1;
      stop_set = poke && (c_hi == 1);
      if (tb_scl_pull && !scl_drive_low && !pulled && left > 0) begin
        left--;
        if (left == 0) tb_scl_pull = 1'b0;
      end
      if (scl_coll && c_hi == 2 && !pulled) begin
        tb_scl_pull = 1'b1;
        pulled = 1;
      end
    end
    stop_set = 1'b0;
    chk(iter < 2000, "R4 sequence terminates", iter, 0);
    chk(!sda_drive_low && !scl_drive_low, "R1 lines released at end",
        {sda_drive_low, scl_drive_low}, 0);
    if (sda_coll) begin
      chk(bcl_flag && !done_flag && !stop_det_flag, "R7 sda collision flags",
          {bcl_flag, stop_det_flag, done_flag}, 4);
    end else if (scl_coll) begin
      chk(bcl_flag && !done_flag && !stop_det_flag, "R8 scl collision flags",
          {bcl_flag, stop_det_flag, done_flag}, 4);
      chk(!sda_rel_seen, "R8 sda never released", sda_rel_seen, 0);
    end else begin
      chk(c_both == 3, "R3 both lines driven cycles", c_both, 3);
      chk(c_hi == n + 4, (stretch > 0) ? "R4 R5 scl-high phase after stretch" :
          (reload == 0 ? "R11 R5 scl-high phase reload 0" : "R5 scl-high phase"), c_hi, n + 4);
      chk(c_rel == n + 3, "R6 sda-high phase before done", c_rel, n + 3);
      chk(done_flag && stop_det_flag && !bcl_flag, "R6 completion flags",
          {bcl_flag, stop_det_flag, done_flag}, 3);
    end
    tb_sda_pull = 1'b0;
    tb_scl_pull = 1'b0;
    if (poke) begin
      repeat (8) @(negedge clk);
      chk(!stop_en && !sda_drive_low, "R9 no second sequence", stop_en, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!stop_en && !done_flag && !stop_det_flag && !bcl_flag &&
        !sda_drive_low && !scl_drive_low, "R1 reset state",
        {stop_en, done_flag, stop_det_flag, bcl_flag, sda_drive_low, scl_drive_low}, 0);

    @(posedge clk); #1 stop_set = 1'b1;
    @(posedge clk); #1 stop_set = 1'b0;
    @(negedge clk);
    chk(stop_en && sda_drive_low && scl_drive_low, "R2 start drives both lines",
        {stop_en, sda_drive_low, scl_drive_low}, 7);
    repeat (40) @(negedge clk);

    for (int r = 0; r < 128; r++) run_stop(r, r % 4, 0, 0, 0);

    pulse_clr(3'b001);
    chk(!done_flag && stop_det_flag, "R10 clear bit0 only", {stop_det_flag, done_flag}, 2);
    pulse_clr(3'b010);
    chk(!stop_det_flag && !done_flag, "R10 clear bit1", {stop_det_flag, done_flag}, 0);

    run_stop(5, 0, 1, 0, 0);
    run_stop(0, 2, 1, 0, 0);
    pulse_clr(3'b011);
    chk(bcl_flag, "R10 bcl sticky under bit0/1 clear", bcl_flag, 1);
    pulse_clr(3'b100);
    chk(!bcl_flag, "R10 clear bit2", bcl_flag, 0);

    run_stop(8, 0, 0, 1, 0);
    run_stop(20, 3, 0, 1, 0);
    run_stop(6, 0, 0, 0, 1);
    run_stop(1, 10, 0, 0, 1);
    run_stop(127, 25, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule